// File: doc/BRIEF.md
# Secondary Interrupt Controller with Direct Routing

This block gathers thirty-two level-sensitive interrupt sources for a primary interrupt controller that has too few inputs of its own. Every source has a raw status bit that tracks its input line and an enable bit. All enabled sources that are active are merged into a single summary line, which is wired to one input of the primary controller.

A second, independent register selects sources in a fixed window of bit positions, 21 through 30. A selected source also drives the primary-controller line with its own number, with no dependence on its enable bit. This lets a few latency-critical sources skip the summary path.

Software reaches the block through a small word-indexed register port. A software-interrupt latch can be set and cleared from that port, and it shows up as source 0. Outputs are registered. Read data arrives in the cycle after the access.

Top module: `sec_irq_ctrl`

## Requirements
- R1: With rst_n low at a clock edge, the enable mask, the routing mask and the software-interrupt latch become zero. irq_summary, irq_direct and bus_rdata read zero after that edge.
- R2: A write to index 2 ORs bus_wdata into the enable mask. A write to index 3 clears every enable bit that is set in bus_wdata. A read of index 2 returns the enable mask.
- R3: The raw status is irq_in OR'd with the software-interrupt latch at bit 0. A read of index 1 returns the raw status sampled in the select cycle.
- R4: A read of index 0 returns the raw status AND the enable mask.
- R5: A write to index 4 with nonzero data sets the software-interrupt latch. A write to index 5 with nonzero data clears it. A zero data word at either index changes nothing. A read of index 4 returns raw bit 0 in bit 0 and zeros above it.
- R6: A write to index 8 sets routing bits from bus_wdata, but only for bits 21 to 30 (mask 0x7FE00000). A write to index 9 clears the routing bits that are set in bus_wdata. A read of index 8 returns the routing mask.
- R7: One clock after an input or register change, irq_direct equals the raw status AND the routing mask. It is independent of the enable mask, and its bits outside 21..30 are always zero.
- R8: One clock after an input or register change, irq_summary is high exactly when the raw status AND the enable mask is nonzero.
- R9: Reads of any index other than 0, 1, 2, 4 and 8 return zero. This includes indices with any of bits 9..4 set. Writes to any index other than 2, 3, 4, 5, 8 and 9 leave all state unchanged.
- R10: bus_rdata holds the read result in the cycle after a select with bus_we low. In every other cycle it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | High for a write, low for a read |
| bus_idx | input | 10 | Word index (byte offset divided by four) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| irq_summary | output | 1 | OR of enabled active sources, to primary line 31 |
| irq_direct | output | 32 | Per-source routed lines to the same-numbered primary inputs |

## Verification
The bench builds the block with its default parameters: thirty-two sources, a 10-bit index and a routing window of bits 21 to 30. With these values the window edges at bits 20, 21, 30 and 31 can be reached, as can the software-interrupt merge on bit 0 and index decoding with upper index bits set. Random writes, including zero and single-bit data words, mix with random input changes, so the enable and routing masks reach many partial states. The summary and routed outputs are then compared against a reference model.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    // Word indices that the register port decodes.
    typedef enum logic [3:0] {
        IX_STATUS    = 4'd0,
        IX_RAW       = 4'd1,
        IX_EN_SET    = 4'd2,
        IX_EN_CLR    = 4'd3,
        IX_SWI_SET   = 4'd4,
        IX_SWI_CLR   = 4'd5,
        IX_ROUTE_SET = 4'd8,
        IX_ROUTE_CLR = 4'd9
    } sirq_idx_e;

    localparam int unsigned DEC_W = 4;

endpackage

// File: rtl/sirq_regs.sv
module sirq_regs
    import sirq_pkg::*;
#(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = 10,
    parameter logic [N-1:0] ROUTE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [N-1:0]     wdata,
    output logic [N-1:0]     en_q,
    output logic [N-1:0]     route_q,
    output logic             swi_q
);
    logic            in_window;
    logic [N-1:0]    en_d;
    logic [N-1:0]    route_d;
    logic            swi_d;
    logic            data_nz;

    assign in_window = (idx[IDX_W-1:DEC_W] == '0);
    assign data_nz   = |wdata;

    always_comb begin
        en_d    = en_q;
        route_d = route_q;
        swi_d   = swi_q;
        if (wr_en && in_window) begin
            case (idx[DEC_W-1:0])
                IX_EN_SET:    en_d    = en_q | wdata;
                IX_EN_CLR:    en_d    = en_q & ~wdata;
                IX_SWI_SET:   if (data_nz) swi_d = 1'b1;
                IX_SWI_CLR:   if (data_nz) swi_d = 1'b0;
                IX_ROUTE_SET: route_d = route_q | (wdata & ROUTE_MASK);
                IX_ROUTE_CLR: route_d = route_q & ~wdata;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            route_q <= '0;
            swi_q   <= 1'b0;
        end else begin
            en_q    <= en_d;
            route_q <= route_d;
            swi_q   <= swi_d;
        end
    end
endmodule

// File: rtl/sirq_read_port.sv
module sirq_read_port
    import sirq_pkg::*;
#(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [N-1:0]     raw,
    input  logic [N-1:0]     en,
    input  logic [N-1:0]     route,
    output logic [N-1:0]     rdata_q
);
    logic         in_window;
    logic [N-1:0] sel_val;

    assign in_window = (idx[IDX_W-1:DEC_W] == '0);

    always_comb begin
        sel_val = '0;
        if (in_window) begin
            case (idx[DEC_W-1:0])
                IX_STATUS:    sel_val = raw & en;
                IX_RAW:       sel_val = raw;
                IX_EN_SET:    sel_val = en;
                IX_SWI_SET:   sel_val = {{(N-1){1'b0}}, raw[0]};
                IX_ROUTE_SET: sel_val = route;
                default:      sel_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= sel_val;
        else            rdata_q <= '0;
    end
endmodule

// File: rtl/sirq_out_stage.sv
module sirq_out_stage #(
    parameter int unsigned N     = 32,
    parameter int unsigned PT_LO = 21,
    parameter int unsigned PT_HI = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] en,
    input  logic [N-1:0] route,
    output logic         summary_q,
    output logic [N-1:0] direct_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) summary_q <= 1'b0;
        else        summary_q <= |(raw & en);
    end

    for (genvar g = 0; g < N; g++) begin : g_lane
        if (g >= PT_LO && g <= PT_HI) begin : g_routed
            always_ff @(posedge clk) begin
                if (!rst_n) direct_q[g] <= 1'b0;
                else        direct_q[g] <= raw[g] & route[g];
            end
        end else begin : g_tied
            assign direct_q[g] = 1'b0;
        end
    end
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl #(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned PT_LO = 21,
    parameter int unsigned PT_HI = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     irq_in,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [N-1:0]     bus_wdata,
    output logic [N-1:0]     bus_rdata,
    output logic             irq_summary,
    output logic [N-1:0]     irq_direct
);
    localparam logic [N-1:0] ROUTE_MASK =
        ({N{1'b1}} >> (N - 1 - PT_HI)) & ({N{1'b1}} << PT_LO);

    logic [N-1:0] en_q;
    logic [N-1:0] route_q;
    logic         swi_q;
    logic [N-1:0] raw;

    assign raw = irq_in | {{(N-1){1'b0}}, swi_q};

    sirq_regs #(.N(N), .IDX_W(IDX_W), .ROUTE_MASK(ROUTE_MASK)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_sel & bus_we), .idx(bus_idx),
        .wdata(bus_wdata), .en_q(en_q), .route_q(route_q), .swi_q(swi_q)
    );

    sirq_read_port #(.N(N), .IDX_W(IDX_W)) i_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_sel & ~bus_we), .idx(bus_idx),
        .raw(raw), .en(en_q), .route(route_q), .rdata_q(bus_rdata)
    );

    sirq_out_stage #(.N(N), .PT_LO(PT_LO), .PT_HI(PT_HI)) i_out (
        .clk(clk), .rst_n(rst_n), .raw(raw), .en(en_q), .route(route_q),
        .summary_q(irq_summary), .direct_q(irq_direct)
    );
endmodule

// File: rtl/sirq_chk.sv
module sirq_chk #(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned PT_LO = 21,
    parameter int unsigned PT_HI = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     irq_in,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [IDX_W-1:0] bus_idx,
    input logic [N-1:0]     bus_wdata,
    input logic [N-1:0]     bus_rdata,
    input logic             irq_summary,
    input logic [N-1:0]     irq_direct
);
    localparam logic [N-1:0] WIN =
        ({N{1'b1}} >> (N - 1 - PT_HI)) & ({N{1'b1}} << PT_LO);

    logic rd_req;
    logic rd_defined;
    assign rd_req = bus_sel && !bus_we;
    assign rd_defined = (bus_idx == IDX_W'(0)) || (bus_idx == IDX_W'(1)) ||
                        (bus_idx == IDX_W'(2)) || (bus_idx == IDX_W'(4)) ||
                        (bus_idx == IDX_W'(8));

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (irq_summary == 1'b0 && irq_direct == '0 && bus_rdata == '0)); // R1

    AST_RAW_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_idx == IDX_W'(1)) |=> (bus_rdata[N-1:1] == $past(irq_in[N-1:1]))); // R3

    AST_ROUTE_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_idx == IDX_W'(8)) |=> ((bus_rdata & ~WIN) == '0)); // R6

    AST_DIRECT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_direct & ~WIN) == '0); // R7

    AST_DIRECT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((irq_direct & ~$past(irq_in)) == '0)); // R7

    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_defined) |=> (bus_rdata == '0)); // R9

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (bus_rdata == '0)); // R10
endmodule

bind sec_irq_ctrl sirq_chk #(.N(N), .IDX_W(IDX_W), .PT_LO(PT_LO), .PT_HI(PT_HI)) i_chk (.*);

// File: tb/test_sec_irq_ctrl.sv
`timescale 1ns/1ps
module test_sec_irq_ctrl;
    localparam logic [31:0] WIN = 32'h7FE0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_idx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_summary;
    logic [31:0] irq_direct;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_en = '0, m_pt = '0;
    logic        m_swi = 1'b0;

    always #5 clk = ~clk;

    sec_irq_ctrl i_sec_irq_ctrl (.*);

    function automatic logic [31:0] m_raw();
        return irq_in | {31'b0, m_swi};
    endfunction

    function automatic logic [31:0] exp_read(input logic [9:0] ix);
        if (ix > 10'd15) return '0;
        case (ix[3:0])
            4'd0: return m_raw() & m_en;
            4'd1: return m_raw();
            4'd2: return m_en;
            4'd4: return {31'b0, m_raw()[0]};
            4'd8: return m_pt;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] ix, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_idx = ix; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        if (ix <= 10'd15) begin
            case (ix[3:0])
                4'd2: m_en = m_en | d;
                4'd3: m_en = m_en & ~d;
                4'd4: if (d != 0) m_swi = 1'b1;
                4'd5: if (d != 0) m_swi = 1'b0;
                4'd8: m_pt = m_pt | (d & WIN);
                4'd9: m_pt = m_pt & ~d;
                default: ;
            endcase
        end
    endtask

    task automatic rd_check(input string req, input logic [9:0] ix);
        logic [31:0] e;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_idx = ix;
        e = exp_read(ix);
        @(negedge clk);
        bus_sel = 1'b0;
        check(req, bus_rdata, e);
    endtask

    task automatic out_check();
        @(negedge clk);
        check("R8 summary", {31'b0, irq_summary}, {31'b0, |(m_raw() & m_en)});
        check("R7 direct", irq_direct, m_raw() & m_pt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R10: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 summary", {31'b0, irq_summary}, 32'd0);
        check("R1 direct", irq_direct, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        rst_n = 1'b1;
        rd_check("R1 enable", 10'd2);
        rd_check("R1 route", 10'd8);
        rd_check("R1 swi", 10'd4);

        // R6 routing window restriction
        wr(10'd8, 32'hFFFF_FFFF);
        rd_check("R6 route set", 10'd8);
        check("R6 window", m_pt, WIN);
        // R7 direct independent of enable, edges 20/21/30/31
        @(negedge clk); irq_in = 32'hC030_0000;
        out_check();
        wr(10'd9, 32'h4000_0000);
        out_check();
        rd_check("R6 route clr", 10'd8);

        // R2 enable set/clear, R8 summary
        wr(10'd2, 32'h0010_0000);
        out_check();
        rd_check("R4 status", 10'd0);
        wr(10'd3, 32'hFFFF_FFFF);
        out_check();
        rd_check("R2 enable", 10'd2);

        // R5 software interrupt
        wr(10'd2, 32'h1);
        wr(10'd4, 32'h0);
        out_check();
        rd_check("R5 swi zero write", 10'd4);
        wr(10'd4, 32'h8);
        out_check();
        rd_check("R5 swi set", 10'd4);
        rd_check("R3 raw bit0", 10'd1);
        wr(10'd5, 32'h0);
        rd_check("R5 swi clr zero", 10'd4);
        wr(10'd5, 32'h2);
        out_check();
        rd_check("R5 swi clr", 10'd4);

        // R9 undefined indices
        wr(10'd7, 32'hFFFF_FFFF);
        wr(10'd0, 32'hFFFF_FFFF);
        wr(10'h012, 32'hFFFF_FFFF);
        rd_check("R9 en unchanged", 10'd2);
        rd_check("R9 route unchanged", 10'd8);
        rd_check("R9 read 3", 10'd3);
        rd_check("R9 read 9", 10'd9);
        rd_check("R9 read high idx", 10'h3F1);
        // R10 idle rdata
        @(negedge clk);
        check("R10 idle", bus_rdata, 32'd0);

        // random phase
        for (int i = 0; i < 400; i++) begin
            int unsigned op;
            logic [31:0] d;
            logic [9:0] ix;
            op = $urandom_range(0, 3);
            case ($urandom_range(0, 3))
                0: d = 32'd0;
                1: d = 32'd1 << $urandom_range(0, 31);
                default: d = $urandom;
            endcase
            ix = ($urandom_range(0, 7) == 0) ? 10'($urandom) : 10'($urandom_range(0, 11));
            if (op == 0) begin
                @(negedge clk); irq_in = $urandom;
            end else begin
                wr(ix, d);
            end
            out_check();
            rd_check("R3/R4 random read", 10'($urandom_range(0, 11)));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule